// File: doc/BRIEF.md
# Interrupt Request Arbiter

This block sits between a processor core and its interrupt sources and decides, once per instruction boundary, whether an interrupt is to be entered and which one. It sees three classes of source. The first is a reset-class request that cannot be masked. The second is a small set of non-maskable sources, each with its own enable bit. The third is a larger set of maskable sources, each with its own arm bit and all of them also gated by the global enable bit of the status register. Every external request passes through a two-flop synchronizer before it is evaluated.

When an interrupt is accepted, the block raises a one-cycle take pulse and presents the index of the winning vector-table entry. For a source that owns its vector alone, the block issues a one-cycle clear pulse back to that source's flag. For sources that share one vector, no clear pulse is sent and software must clear the flag. After a take, the block accepts no further interrupt except reset until the core acknowledges that the entry sequence has finished. The core is expected to hold the acknowledge back for at least two cycles after the take, so that a cleared flag has passed through the synchronizer before the block can grant again.

Top module: `irq_arbiter`

## Requirements
- R1: After rst_n is released, and before any request, take, vec, nmi_clr and irq_clr are all zero.
- R2: A maskable source i is eligible only when irq_req[i], irq_arm[i] and gie are all high. If any one of them is low, that source never wins.
- R3: A non-maskable source j is eligible when nmi_req[j] and nmi_en[j] are high, whatever the value of gie. If nmi_en[j] is low, it is blocked.
- R4: Any eligible non-maskable source beats every maskable source. Within each class, the eligible source with the lowest index wins.
- R5: Vector encoding: reset-class is 0. Non-maskable source j is 1+j. Maskable sources 0..N_SHARED-1 share vector N_NMI+1. Maskable source i with i >= N_SHARED is N_NMI+2+(i-N_SHARED). With the defaults (N_NMI=2, N_MSK=6, N_SHARED=2) this gives nmi 1,2; shared 3; maskable sources 2..5 as 4..7.
- R6: A non-reset interrupt is granted only in a cycle in which insn_done is high. take rises for exactly one cycle, at the clock edge that samples insn_done, and vec is valid while take is high.
- R7: A rising edge of the synchronized rst_req produces take with vec 0 on the edge after it is synchronized. This happens regardless of insn_done, gie, busy state or any other pending request, and without any clear pulse.
- R8: With each take of a non-maskable source or of a non-shared maskable source, exactly that source's clear bit pulses for the same cycle. A take of a shared vector pulses no clear bit. At most one clear bit is high at a time, and only while take is high.
- R9: A shared-vector source whose flag remains set is granted again at the next eligible boundary.
- R10: After any take, no take other than reset occurs until entry_ack has been sampled high. The cycle in which entry_ack is high is itself still blocked.
- R11: A request must be sampled by two clock edges before the edge that evaluates it. A request that rises just before a boundary edge is not granted at that edge or at the next one, and is granted at the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rst_req | input | 1 | Reset-class interrupt request (asynchronous) |
| nmi_req | input | N_NMI | Non-maskable request flags (asynchronous) |
| nmi_en | input | N_NMI | Per-source enable for non-maskable sources |
| irq_req | input | N_MSK | Maskable request flags (asynchronous) |
| irq_arm | input | N_MSK | Per-source arm bits for maskable sources |
| gie | input | 1 | Global enable bit from the status register |
| insn_done | input | 1 | Instruction-boundary strobe |
| entry_ack | input | 1 | Core signals that the entry sequence has finished |
| take | output | 1 | One-cycle pulse: interrupt accepted |
| vec | output | VEC_W | Index of the accepted vector-table entry |
| nmi_clr | output | N_NMI | One-cycle flag-clear pulses for non-maskable sources |
| irq_clr | output | N_MSK | One-cycle flag-clear pulses for maskable sources |

## Verification
The bench aims at the collisions between classes. Reset arriving together with a pending non-maskable request must win. A non-maskable request must still be taken while gie is clear. A design that ranked reset behind the boundary grant, or gated the non-maskable class with gie, would report the wrong vector or no take at all. It also holds insn_done high while an entry is still unacknowledged, and checks that a shared vector is retaken while its flag stays set but never produces a clear pulse. A design without the busy hold would issue a second take, and one that auto-cleared shared vectors would lose pending sources. Finally, a request that rises just before a boundary must stay invisible for two edges. A design with a missing or single synchronizer stage would grant one edge early.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Number of vector-table entries: reset, one per non-maskable source,
  // one shared entry (if any sources share), one per remaining maskable source.
  function automatic int vec_total(int nn, int nm, int ns);
    return 1 + nn + ((ns > 0) ? 1 : 0) + (nm - ns);
  endfunction

  // Vector index of maskable source i.
  function automatic int msk_vec(int nn, int ns, int i);
    if (i < ns) return 1 + nn;
    return 1 + nn + ((ns > 0) ? 1 : 0) + (i - ns);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg1_q, stg2_q;
  logic [W-1:0] stg1_d, stg2_d;

  always_comb begin
    stg1_d = d;
    stg2_d = stg1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= stg1_d;
      stg2_q <= stg2_d;
    end
  end

  assign q = stg2_q;

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int N_NMI    = 2,
  parameter int N_MSK    = 6,
  parameter int N_SHARED = 2,
  parameter int VEC_W    = 3
) (
  input  logic [N_NMI-1:0] nmi_s,
  input  logic [N_NMI-1:0] nmi_en,
  input  logic [N_MSK-1:0] irq_s,
  input  logic [N_MSK-1:0] irq_arm,
  input  logic             gie,
  output logic             g_valid,
  output logic [VEC_W-1:0] g_vec,
  output logic [N_NMI-1:0] g_nclr,
  output logic [N_MSK-1:0] g_iclr
);

  logic [N_NMI-1:0] nmi_ok;
  logic [N_MSK-1:0] irq_ok;
  logic             found;

  assign nmi_ok = nmi_s & nmi_en;
  assign irq_ok = irq_s & irq_arm & {N_MSK{gie}};

  always_comb begin
    found  = 1'b0;
    g_vec  = '0;
    g_nclr = '0;
    g_iclr = '0;
    for (int j = 0; j < N_NMI; j++) begin
      if (!found && nmi_ok[j]) begin
        found     = 1'b1;
        g_vec     = VEC_W'(1 + j);
        g_nclr[j] = 1'b1;
      end
    end
    for (int i = 0; i < N_MSK; i++) begin
      if (!found && irq_ok[i]) begin
        found = 1'b1;
        g_vec = VEC_W'(msk_vec(N_NMI, N_SHARED, i));
        if (i >= N_SHARED) g_iclr[i] = 1'b1;
      end
    end
    g_valid = found;
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_NMI    = 2,
  parameter int N_MSK    = 6,
  parameter int N_SHARED = 2,
  parameter int VEC_W    = $clog2(vec_total(N_NMI, N_MSK, N_SHARED))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_req,
  input  logic [N_NMI-1:0] nmi_req,
  input  logic [N_NMI-1:0] nmi_en,
  input  logic [N_MSK-1:0] irq_req,
  input  logic [N_MSK-1:0] irq_arm,
  input  logic             gie,
  input  logic             insn_done,
  input  logic             entry_ack,
  output logic             take,
  output logic [VEC_W-1:0] vec,
  output logic [N_NMI-1:0] nmi_clr,
  output logic [N_MSK-1:0] irq_clr
);

  localparam int SYNC_W   = 1 + N_NMI + N_MSK;
  localparam int MSK_BASE = 1 + N_NMI;

  logic [SYNC_W-1:0] req_s;
  logic              rst_s;
  logic [N_NMI-1:0]  nmi_s;
  logic [N_MSK-1:0]  irq_s;

  irq_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({rst_req, nmi_req, irq_req}),
    .q     (req_s)
  );

  assign {rst_s, nmi_s, irq_s} = req_s;

  logic             g_valid;
  logic [VEC_W-1:0] g_vec;
  logic [N_NMI-1:0] g_nclr;
  logic [N_MSK-1:0] g_iclr;

  irq_select #(
    .N_NMI(N_NMI), .N_MSK(N_MSK), .N_SHARED(N_SHARED), .VEC_W(VEC_W)
  ) u_sel (
    .nmi_s   (nmi_s),
    .nmi_en  (nmi_en),
    .irq_s   (irq_s),
    .irq_arm (irq_arm),
    .gie     (gie),
    .g_valid (g_valid),
    .g_vec   (g_vec),
    .g_nclr  (g_nclr),
    .g_iclr  (g_iclr)
  );

  logic             rst_prev_q, rst_prev_d;
  logic             busy_q, busy_d;
  logic             take_q, take_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_en;
  logic [N_NMI-1:0] nclr_q, nclr_d;
  logic [N_MSK-1:0] iclr_q, iclr_d;
  logic             rst_edge, grant_ok;

  always_comb begin
    rst_edge   = rst_s & ~rst_prev_q;
    grant_ok   = insn_done & ~busy_q & g_valid;
    take_d     = rst_edge | grant_ok;
    vec_en     = take_d;
    vec_d      = rst_edge ? '0 : g_vec;
    nclr_d     = (grant_ok && !rst_edge) ? g_nclr : '0;
    iclr_d     = (grant_ok && !rst_edge) ? g_iclr : '0;
    rst_prev_d = rst_s;
    if (take_d)         busy_d = 1'b1;
    else if (entry_ack) busy_d = 1'b0;
    else                busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_prev_q <= 1'b0;
      busy_q     <= 1'b0;
      take_q     <= 1'b0;
      vec_q      <= '0;
      nclr_q     <= '0;
      iclr_q     <= '0;
    end else begin
      rst_prev_q <= rst_prev_d;
      busy_q     <= busy_d;
      take_q     <= take_d;
      nclr_q     <= nclr_d;
      iclr_q     <= iclr_d;
      if (vec_en) vec_q <= vec_d;
    end
  end

  assign take    = take_q;
  assign vec     = vec_q;
  assign nmi_clr = nclr_q;
  assign irq_clr = iclr_q;

  // Non-reset takes occur only on a boundary strobe.
  assert_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && vec_q != '0) |-> $past(insn_done));

  // While an entry is in progress, only reset may be taken.
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!take_q || vec_q == '0));

  // Maskable vectors require the global enable.
  assert_gie_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && vec_q >= VEC_W'(MSK_BASE)) |-> $past(gie));

  // Clear pulses are single and accompany a take.
  assert_clr_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nclr_q, iclr_q}));

  assert_clr_with_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|{nclr_q, iclr_q}) |-> (take_q && vec_q != '0));

  // Reset vector never carries a clear pulse.
  assert_rst_noclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && vec_q == '0) |-> ({nclr_q, iclr_q} == '0));

endmodule

// File: tb/irq_arbiter_tb_top.sv
module irq_arbiter_tb_top;

  localparam int NN = 2;
  localparam int NM = 6;
  localparam int NS = 2;
  localparam int VW = 3;

  logic          clk, rst_n, rst_req, gie, insn_done, entry_ack;
  logic [NN-1:0] nmi_req, nmi_en, nmi_clr;
  logic [NM-1:0] irq_req, irq_arm, irq_clr;
  logic          take;
  logic [VW-1:0] vec;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  irq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
    .nmi_req(nmi_req), .nmi_en(nmi_en),
    .irq_req(irq_req), .irq_arm(irq_arm), .gie(gie),
    .insn_done(insn_done), .entry_ack(entry_ack),
    .take(take), .vec(vec), .nmi_clr(nmi_clr), .irq_clr(irq_clr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      tests++; fails++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Expected outcome from the requirements (R2..R5, R8).
  task automatic model(output logic etake, output logic [VW-1:0] evec,
                       output logic [NN-1:0] enc, output logic [NM-1:0] eic);
    etake = 1'b0; evec = '0; enc = '0; eic = '0;
    for (int j = NN - 1; j >= 0; j--)
      if (nmi_req[j] && nmi_en[j]) begin
        etake = 1'b1; evec = VW'(1 + j); enc = '0; enc[j] = 1'b1;
      end
    if (!etake)
      for (int i = NM - 1; i >= 0; i--)
        if (irq_req[i] && irq_arm[i] && gie) begin
          etake = 1'b1; eic = '0;
          if (i < NS) evec = VW'(NN + 1);
          else begin evec = VW'(NN + 2 + (i - NS)); eic[i] = 1'b1; end
        end
  endtask

  task automatic ack_entry();
    @(negedge clk); entry_ack = 1'b1;
    @(negedge clk); entry_ack = 1'b0;
  endtask

  // Settle inputs through the synchronizer, strobe one boundary, check.
  task automatic trial(input string tag);
    logic etake; logic [VW-1:0] evec; logic [NN-1:0] enc; logic [NM-1:0] eic;
    repeat (3) @(negedge clk);
    model(etake, evec, enc, eic);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    chk({tag, " take R2 R3 R6"}, 32'(take), 32'(etake));
    if (etake) chk({tag, " vec R4 R5"}, 32'(vec), 32'(evec));
    chk({tag, " nmi_clr R8"}, 32'(nmi_clr), 32'(enc));
    chk({tag, " irq_clr R8"}, 32'(irq_clr), 32'(eic));
    @(negedge clk);
    chk({tag, " one-cycle take R6"}, 32'(take), 32'd0);
    if (etake) begin
      insn_done = 1'b1;
      @(negedge clk);
      insn_done = 1'b0;
      chk({tag, " busy blocks R10"}, 32'(take), 32'd0);
      ack_entry();
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rst_req = 0; gie = 0; insn_done = 0; entry_ack = 0;
    nmi_req = '0; nmi_en = '0; irq_req = '0; irq_arm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset take R1", 32'(take), 0);
    chk("reset vec R1", 32'(vec), 0);
    chk("reset clr R1", 32'({nmi_clr, irq_clr}), 0);

    // R2: each of the three conditions missing in turn.
    irq_req = 6'b000100; irq_arm = 6'b000100; gie = 0; trial("R2 gie low");
    gie = 1; irq_arm = 6'b0; trial("R2 arm low");
    irq_arm = 6'b000100; irq_req = 6'b0; trial("R2 req low");
    irq_req = 6'b000100; trial("R2 all high");

    // R3: NMI with gie clear; NMI blocked by its own enable.
    gie = 0; nmi_req = 2'b10; nmi_en = 2'b10; trial("R3 nmi gie low");
    nmi_en = 2'b01; trial("R3 nmi disabled");

    // R4: NMI beats maskable; lowest index wins.
    gie = 1; nmi_req = 2'b11; nmi_en = 2'b11; irq_req = 6'b111111; irq_arm = 6'b111111;
    trial("R4 nmi over irq");
    nmi_req = 2'b0; irq_req = 6'b110100; trial("R4 lowest irq");

    // R9: shared vector retaken while its flag stays set, no clear pulse.
    irq_req = 6'b000010; trial("R9 shared first");
    trial("R9 shared again");

    // R11: request rising just before a boundary edge.
    irq_req = 6'b0; nmi_req = 2'b0;
    repeat (3) @(negedge clk);
    irq_req = 6'b001000; insn_done = 1'b1;
    @(negedge clk); chk("R11 edge1 no take", 32'(take), 0);
    @(negedge clk); chk("R11 edge2 no take", 32'(take), 0);
    @(negedge clk); insn_done = 1'b0;
    chk("R11 edge3 take", 32'(take), 1);
    chk("R11 edge3 vec", 32'(vec), 5);
    ack_entry();

    // R7: reset together with a pending NMI and the strobe held high.
    irq_req = 6'b0;
    repeat (3) @(negedge clk);
    nmi_req = 2'b01; nmi_en = 2'b01; rst_req = 1'b1; insn_done = 1'b1;
    @(negedge clk); chk("R7 edge1", 32'(take), 0);
    @(negedge clk); chk("R7 edge2", 32'(take), 0);
    @(negedge clk); chk("R7 take", 32'(take), 1);
    chk("R7 vec0", 32'(vec), 0);
    chk("R7 no clr", 32'({nmi_clr, irq_clr}), 0);
    @(negedge clk); chk("R7 then busy R10", 32'(take), 0);
    insn_done = 1'b0; rst_req = 1'b0; nmi_req = 2'b0;
    ack_entry();

    // R7: reset while busy and no boundary strobe.
    irq_req = 6'b100000; irq_arm = 6'b100000; gie = 1;
    repeat (3) @(negedge clk);
    insn_done = 1'b1; @(negedge clk); insn_done = 1'b0;
    chk("R7 pre take", 32'(take), 1);
    rst_req = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R7 busy edge2", 32'(take), 0);
    @(negedge clk);
    chk("R7 busy take", 32'(take), 1);
    chk("R7 busy vec0", 32'(vec), 0);
    rst_req = 1'b0; irq_req = 6'b0;
    ack_entry();

    // Random mix.
    for (int k = 0; k < 300; k++) begin
      nmi_req = NN'($urandom()); nmi_en = NN'($urandom());
      if ($urandom_range(0, 3) != 0) nmi_req = '0;
      irq_req = NM'($urandom()); irq_arm = NM'($urandom());
      gie = 1'($urandom());
      trial("random R2 R3 R4 R5 R8");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule